// File: doc/BRIEF.md
# Cartridge Program Bank Controller

This block sits on the CPU side of a cartridge memory mapper. It watches CPU write cycles. From a few CPU address pins it forms a two-bit register select, and it loads two 5-bit program bank registers, a banking-mode bit and a nametable mirroring code. It drives the bank number for each of the four 8 KiB CPU windows at 8000–FFFF. It also holds a one-bit latch in the 6000–7FFF range, which the CPU can write and read back on boards that have no work RAM.

The board variant is a static input. It sets which address pins act as the two select bits, whether the mode bit exists, and how wide the mirroring range is. A heuristic input covers cases where the exact board is unknown. In that mode each select bit is the OR of the pins used by the two boards that share the same board number. The number of program banks is a parameter, and every bank output is wrapped to that count.

Top module: `prg_bank_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both bank registers, the mode bit, the mirroring code and the latch to zero.
- R2: With mode 0, the window outputs (window k at bits k*BW+BW-1 : k*BW) carry bank register 0, bank register 1, bank count minus 2, and bank count minus 1, from window 0 to window 3.
- R3: With mode 1, the windows carry bank count minus 2, bank register 1, bank register 0, and bank count minus 1. Window 3 stays the last bank in both modes.
- R4: A bank register keeps only data bits 4:0. Its window output is that value modulo NUM_BANKS.
- R5: A write to any address with bits 15:12 equal to 8 loads bank register 0. A write with bits 15:12 equal to A loads bank register 1. The low address bits do not matter.
- R6: Outside heuristic mode, the select pins {S1,S0} depend on the variant code. 0: S0=a1, S1=a0. 1: S0=a0, S1=a1. 2: S0=a1, S1=a0. 3: S0=a1, S1=a2. 4: S0=a1, S1=a0. 5: S0=a6, S1=a7. 6: S0=a3, S1=a2. 7: S0=a2, S1=a3. 8: S0=a0, S1=a1.
- R7: With `heuristic_i` high and a variant other than 0 or 8, the select bits are ORs of pin pairs. For variants 2, 4 and 6: S0=a1|a3, S1=a0|a2. For variants 3 and 5: S0=a1|a6, S1=a2|a7. For variants 1 and 7: S0=a0|a2, S1=a1|a3.
- R8: For variants 3 to 8, a write to 9xxx with select 0 or 1 sets the mirroring code to data bits 1:0. The codes are 0 vertical, 1 horizontal, 2 single-screen A and 3 single-screen B.
- R9: For variants 0 to 2, a write to 9xxx with any select sets the mirroring code. In heuristic mode the code is data bits 1:0. Otherwise it is {0, data bit 0}.
- R10: For variants 3 to 8, a write to 9xxx with select 2 or 3 sets the mode bit from data bit 1. For variants 0 to 2 the mode stays 0.
- R11: The latch is enabled for variants 0 to 2 when the effective heuristic mode is off and `wram_fitted_i` is low. While it is enabled, a write to 6000–7FFF stores data bit 0. An access in that range raises `latch_hit_o`, and `latch_rdata_o` then reads {open_bus_i[7:1], latch}.
- R12: No state changes while `cpu_we_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| variant_i | input | 4 | Static board variant code (0–8) |
| heuristic_i | input | 1 | OR the select pins of sibling variants |
| wram_fitted_i | input | 1 | Board has work RAM at 6000–7FFF |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, one cycle per write |
| open_bus_i | input | 8 | Last value seen on the CPU data bus |
| latch_rdata_o | output | 8 | Read value for the 6000–7FFF latch |
| latch_hit_o | output | 1 | Address is in the latch range and the latch exists |
| win_bank_o | output | 4*BW | Bank number for each 8 KiB window |
| mirror_o | output | 2 | Nametable mirroring code |

## Verification
Every variant is swept in both exact and heuristic mode. For each, all 256 low-byte values of a 9xxx address are written, with data that varies alongside the address. This separates the correct select pins from their neighbours, the OR of sibling pins from a single pin, and the masked from the unmasked mirroring data. Bank writes carry values above the bank count and scattered low address bits, in both modes, so window order, the modulo wrap and the insensitivity to the offset are all visible. Writes to the latch, and idle cycles that have the strobe low, are repeated with and without work RAM, so a wrong enable condition or an update without a strobe shows up at the ports.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

   // board variant codes; 0..2 are first generation (no mode bit)
   localparam logic [3:0] BRD_G1_A = 4'd0;
   localparam logic [3:0] BRD_G1_B = 4'd1;
   localparam logic [3:0] BRD_G1_C = 4'd2;
   localparam logic [3:0] BRD_G2_A = 4'd3;
   localparam logic [3:0] BRD_G2_B = 4'd4;
   localparam logic [3:0] BRD_G2_C = 4'd5;
   localparam logic [3:0] BRD_G2_D = 4'd6;
   localparam logic [3:0] BRD_G2_E = 4'd7;
   localparam logic [3:0] BRD_G2_X = 4'd8;

   localparam int REG_W = 5;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_ONE_A = 2'd2,
      MIR_ONE_B = 2'd3
   } mirror_e;

   function automatic logic is_gen1(input logic [3:0] v);
      return v <= BRD_G1_C;
   endfunction

endpackage

// File: rtl/prg_sel_xlate.sv
module prg_sel_xlate
   import prg_bank_pkg::*;
(
   input  logic [3:0] variant_i,
   input  logic       heur_i,
   input  logic [3:0] pin_lo_i,   // address bits 3:0
   input  logic [1:0] pin_hi_i,   // address bits 7:6
   output logic [1:0] sel_o       // {S1,S0}
);

   logic s0, s1;

   always_comb begin
      s0 = pin_lo_i[0];
      s1 = pin_lo_i[1];
      if (heur_i) begin
         unique case (variant_i)
            BRD_G1_C, BRD_G2_B, BRD_G2_D: begin
               s0 = pin_lo_i[1] | pin_lo_i[3];
               s1 = pin_lo_i[0] | pin_lo_i[2];
            end
            BRD_G2_A, BRD_G2_C: begin
               s0 = pin_lo_i[1] | pin_hi_i[0];
               s1 = pin_lo_i[2] | pin_hi_i[1];
            end
            BRD_G1_B, BRD_G2_E: begin
               s0 = pin_lo_i[0] | pin_lo_i[2];
               s1 = pin_lo_i[1] | pin_lo_i[3];
            end
            default: begin
               s0 = pin_lo_i[0];
               s1 = pin_lo_i[1];
            end
         endcase
      end else begin
         unique case (variant_i)
            BRD_G1_A, BRD_G1_C, BRD_G2_B: begin
               s0 = pin_lo_i[1];
               s1 = pin_lo_i[0];
            end
            BRD_G2_A: begin
               s0 = pin_lo_i[1];
               s1 = pin_lo_i[2];
            end
            BRD_G2_C: begin
               s0 = pin_hi_i[0];
               s1 = pin_hi_i[1];
            end
            BRD_G2_D: begin
               s0 = pin_lo_i[3];
               s1 = pin_lo_i[2];
            end
            BRD_G2_E: begin
               s0 = pin_lo_i[2];
               s1 = pin_lo_i[3];
            end
            default: begin
               s0 = pin_lo_i[0];
               s1 = pin_lo_i[1];
            end
         endcase
      end
   end

   assign sel_o = {s1, s0};

endmodule

// File: rtl/prg_regfile.sv
module prg_regfile
   import prg_bank_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             we_i,
   input  logic [3:0]       hi_i,      // address bits 15:12
   input  logic [1:0]       sel_i,
   input  logic [7:0]       data_i,
   input  logic             gen1_i,
   input  logic             heur_i,
   input  logic             latch_en_i,
   output logic [REG_W-1:0] reg0_o,
   output logic [REG_W-1:0] reg1_o,
   output logic             mode_o,
   output mirror_e          mirror_o,
   output logic             latch_o
);

   logic unused_data;
   assign unused_data = ^data_i[7:5];

   logic hit_r0, hit_r1, hit_ctl, hit_lat;
   assign hit_r0  = we_i && (hi_i == 4'h8);
   assign hit_r1  = we_i && (hi_i == 4'hA);
   assign hit_ctl = we_i && (hi_i == 4'h9);
   assign hit_lat = we_i && (hi_i[3:1] == 3'b011) && latch_en_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         reg0_o   <= '0;
         reg1_o   <= '0;
         mode_o   <= 1'b0;
         mirror_o <= MIR_VERT;
         latch_o  <= 1'b0;
      end else begin
         if (hit_r0) reg0_o <= data_i[REG_W-1:0];
         if (hit_r1) reg1_o <= data_i[REG_W-1:0];
         if (hit_ctl) begin
            if (gen1_i)
               mirror_o <= heur_i ? mirror_e'(data_i[1:0]) : mirror_e'({1'b0, data_i[0]});
            else if (!sel_i[1])
               mirror_o <= mirror_e'(data_i[1:0]);
            else
               mode_o <= data_i[1];
         end
         if (hit_lat) latch_o <= data_i[0];
      end
   end

   assert_reg0_load_R5: assert property (@(posedge clk) disable iff (rst)
      (we_i && hi_i == 4'h8) |=> (reg0_o == $past(data_i[REG_W-1:0])));

   assert_reg1_load_R5: assert property (@(posedge clk) disable iff (rst)
      (we_i && hi_i == 4'hA) |=> (reg1_o == $past(data_i[REG_W-1:0])));

   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
      !we_i |=> ($stable(reg0_o) && $stable(reg1_o) && $stable(mode_o)
                 && $stable(mirror_o) && $stable(latch_o)));

   assert_gen1_mode_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (gen1_i && !mode_o && we_i) |=> !mode_o);

   assert_exact_mirror_R9: assert property (@(posedge clk) disable iff (rst)
      (we_i && hi_i == 4'h9 && gen1_i && !heur_i) |=> !mirror_o[1]);

   assert_latch_store_R11: assert property (@(posedge clk) disable iff (rst)
      (we_i && hi_i[3:1] == 3'b011 && latch_en_i) |=> (latch_o == $past(data_i[0])));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
   import prg_bank_pkg::*;
#(
   parameter int NUM_BANKS = 16,
   parameter int BW        = $clog2(NUM_BANKS)
) (
   input  logic [REG_W-1:0] reg0_i,
   input  logic [REG_W-1:0] reg1_i,
   input  logic             mode_i,
   output logic [4*BW-1:0]  win_o
);

   localparam logic [BW-1:0] LAST_BANK   = BW'(NUM_BANKS - 1);
   localparam logic [BW-1:0] SECOND_LAST = BW'(NUM_BANKS - 2);

   logic [BW-1:0] r0w, r1w;

   generate
      if (BW <= REG_W) begin : g_trunc
         assign r0w = reg0_i[BW-1:0];
         assign r1w = reg1_i[BW-1:0];
         if (BW < REG_W) begin : g_sink
            logic unused_hi;
            assign unused_hi = ^{reg0_i[REG_W-1:BW], reg1_i[REG_W-1:BW]};
         end
      end else begin : g_ext
         assign r0w = {{(BW-REG_W){1'b0}}, reg0_i};
         assign r1w = {{(BW-REG_W){1'b0}}, reg1_i};
      end

      for (genvar i = 0; i < 4; i++) begin : g_win
         logic [BW-1:0] bank;
         if (i == 3) begin : g_fixed
            assign bank = LAST_BANK;
         end else if (i == 1) begin : g_r1
            assign bank = r1w;
         end else if (i == 0) begin : g_first
            assign bank = mode_i ? SECOND_LAST : r0w;
         end else begin : g_third
            assign bank = mode_i ? r0w : SECOND_LAST;
         end
         assign win_o[i*BW +: BW] = bank;
      end
   endgenerate

endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
   import prg_bank_pkg::*;
#(
   parameter  int NUM_BANKS = 16,
   localparam int BW        = $clog2(NUM_BANKS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [3:0]      variant_i,
   input  logic            heuristic_i,
   input  logic            wram_fitted_i,
   input  logic [15:0]     cpu_addr_i,
   input  logic [7:0]      cpu_wdata_i,
   input  logic            cpu_we_i,
   input  logic [7:0]      open_bus_i,
   output logic [7:0]      latch_rdata_o,
   output logic            latch_hit_o,
   output logic [4*BW-1:0] win_bank_o,
   output logic [1:0]      mirror_o
);

   generate
      if (NUM_BANKS < 4 || NUM_BANKS > 256 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_cfg
         $error("prg_bank_ctrl: NUM_BANKS must be a power of two from 4 to 256");
      end
   endgenerate

   logic unused_addr;
   assign unused_addr = ^{cpu_addr_i[11:8], cpu_addr_i[5:4], open_bus_i[0]};

   logic             gen1, heur_eff, latch_en;
   logic [1:0]       sel;
   logic [REG_W-1:0] reg0, reg1;
   logic             mode, latch_q;
   mirror_e          mirror;

   assign gen1     = is_gen1(variant_i);
   assign heur_eff = heuristic_i && (variant_i != BRD_G1_A) && (variant_i != BRD_G2_X);
   assign latch_en = gen1 && !heur_eff && !wram_fitted_i;

   prg_sel_xlate u_xlate (
      .variant_i (variant_i),
      .heur_i    (heur_eff),
      .pin_lo_i  (cpu_addr_i[3:0]),
      .pin_hi_i  (cpu_addr_i[7:6]),
      .sel_o     (sel)
   );

   prg_regfile u_regs (
      .clk        (clk),
      .rst        (rst),
      .we_i       (cpu_we_i),
      .hi_i       (cpu_addr_i[15:12]),
      .sel_i      (sel),
      .data_i     (cpu_wdata_i),
      .gen1_i     (gen1),
      .heur_i     (heur_eff),
      .latch_en_i (latch_en),
      .reg0_o     (reg0),
      .reg1_o     (reg1),
      .mode_o     (mode),
      .mirror_o   (mirror),
      .latch_o    (latch_q)
   );

   prg_window_map #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_map (
      .reg0_i (reg0),
      .reg1_i (reg1),
      .mode_i (mode),
      .win_o  (win_bank_o)
   );

   assign mirror_o      = mirror;
   assign latch_hit_o   = latch_en && (cpu_addr_i[15:13] == 3'b011);
   assign latch_rdata_o = {open_bus_i[7:1], latch_q};

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (mirror_o == 2'd0 && !latch_q && !mode
               && win_bank_o[BW-1:0] == '0 && win_bank_o[2*BW-1:BW] == '0));

   assert_no_latch_with_wram_R11: assert property (@(posedge clk) disable iff (rst)
      wram_fitted_i |-> !latch_hit_o);

endmodule

// File: tb/test_prg_bank_ctrl.sv
module test_prg_bank_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 16;
   localparam int BW = $clog2(NB);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [3:0]      variant = '0;
   logic            heur = 1'b0;
   logic            wram = 1'b0;
   logic [15:0]     addr = '0;
   logic [7:0]      wdata = '0;
   logic            we = 1'b0;
   logic [7:0]      obus = '0;
   logic [7:0]      rdata;
   logic            hit;
   logic [4*BW-1:0] win;
   logic [1:0]      mir;

   int checks = 0;
   int errors = 0;

   // reference model state
   int  m_r0, m_r1, m_mode, m_mir, m_latch;

   always #(CLK_PERIOD/2) clk = ~clk;

   prg_bank_ctrl #(.NUM_BANKS(NB)) i_prg_bank_ctrl (
      .clk(clk), .rst(rst), .variant_i(variant), .heuristic_i(heur),
      .wram_fitted_i(wram), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
      .cpu_we_i(we), .open_bus_i(obus), .latch_rdata_o(rdata),
      .latch_hit_o(hit), .win_bank_o(win), .mirror_o(mir)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (variant %0d heur %0d)",
                  req, act, exp, variant, heur);
      end
   endtask

   function automatic bit heur_eff();
      return heur && variant != 0 && variant != 8;
   endfunction

   function automatic bit latch_on();
      return variant <= 2 && !heur_eff() && !wram;
   endfunction

   function automatic int sel_of(input logic [15:0] a);
      bit s0, s1;
      if (heur_eff()) begin
         case (variant)
            2, 4, 6: begin s0 = a[1] | a[3]; s1 = a[0] | a[2]; end
            3, 5:    begin s0 = a[1] | a[6]; s1 = a[2] | a[7]; end
            default: begin s0 = a[0] | a[2]; s1 = a[1] | a[3]; end
         endcase
      end else begin
         case (variant)
            0, 2, 4: begin s0 = a[1]; s1 = a[0]; end
            3:       begin s0 = a[1]; s1 = a[2]; end
            5:       begin s0 = a[6]; s1 = a[7]; end
            6:       begin s0 = a[3]; s1 = a[2]; end
            7:       begin s0 = a[2]; s1 = a[3]; end
            default: begin s0 = a[0]; s1 = a[1]; end
         endcase
      end
      return {s1, s0};
   endfunction

   function automatic logic [4*BW-1:0] exp_win();
      int w0, w2;
      w0 = m_mode ? NB - 2 : m_r0 % NB;
      w2 = m_mode ? m_r0 % NB : NB - 2;
      return {BW'(NB - 1), BW'(w2), BW'(m_r1 % NB), BW'(w0)};
   endfunction

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      if (a[15:13] == 3'b011 && latch_on()) m_latch = d[0];
      if (a[15:12] == 4'h8) m_r0 = d[4:0];
      if (a[15:12] == 4'hA) m_r1 = d[4:0];
      if (a[15:12] == 4'h9) begin
         if (variant <= 2) m_mir = heur_eff() ? d[1:0] : {1'b0, d[0]};
         else if (sel_of(a) < 2) m_mir = d[1:0];
         else m_mode = d[1];
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      model_write(a, d);
   endtask

   task automatic check_windows(input string req);
      chk(req, int'(win), int'(exp_win()));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_r0 = 0; m_r1 = 0; m_mode = 0; m_mir = 0; m_latch = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int v = 0; v <= 8; v++) begin
         for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 2; w++) begin
               variant = 4'(v); heur = h[0]; wram = w[0];
               do_reset();
               // R1: reset state
               chk("R1 mirror", mir, 0);
               check_windows("R1 windows");
               addr = 16'h6000; obus = 8'hFF;
               #1;
               if (hit) chk("R1 latch", rdata[0], 0);

               // mirroring/mode sweep over all low address bytes
               for (int lo = 0; lo < 256; lo++) begin
                  logic [15:0] a;
                  logic [7:0]  d;
                  a = 16'h9000 | 16'(lo) | 16'((lo & 3) << 8);
                  d = 8'(lo ^ (lo >> 2) ^ 8'hA4);
                  wr(a, d);
                  if (v <= 2) chk(heur_eff() ? "R7 R9 mirror" : "R6 R9 mirror", mir, m_mir);
                  else        chk(heur_eff() ? "R7 R8 mirror" : "R6 R8 mirror", mir, m_mir);
                  check_windows("R10 mode via windows");
               end

               // bank registers in both modes
               for (int m = 0; m < 2; m++) begin
                  logic [15:0] ma;
                  ma = 16'h9000;
                  for (int lo = 255; lo >= 0; lo--)
                     if (sel_of(16'h9000 | 16'(lo)) == 2) ma = 16'h9000 | 16'(lo);
                  wr(ma, 8'(m << 1));
                  check_windows("R10 mode set");
                  for (int d = 0; d < 32; d++) begin
                     wr(16'h8000 | 16'((d * 157) & 16'h0FFF), 8'(d | 8'hE0));
                     check_windows(m ? "R3 R4 R5 reg0" : "R2 R4 R5 reg0");
                     wr(16'hA000 | 16'((d * 91) & 16'h0FFF), 8'((31 - d) | 8'h60));
                     check_windows(m ? "R3 R4 R5 reg1" : "R2 R4 R5 reg1");
                  end
               end

               // R12: strobe low, nothing may change
               @(negedge clk);
               addr = 16'h8003; wdata = 8'h1B; we = 1'b0;
               @(negedge clk);
               addr = 16'h9000; wdata = 8'h03;
               @(negedge clk);
               addr = 16'h6000; wdata = 8'h01;
               @(negedge clk);
               check_windows("R12 windows");
               chk("R12 mirror", mir, m_mir);
               obus = 8'h00; addr = 16'h7000; #1;
               if (hit) chk("R12 latch", rdata[0], m_latch);

               // R11: latch write and readback
               wr(16'h6000, 8'hF3);
               obus = 8'hA4; addr = 16'h7FFF; #1;
               chk("R11 hit", hit, latch_on());
               if (hit) chk("R11 rdata", rdata, {obus[7:1], 1'(m_latch)});
               wr(16'h7ABC, 8'h5E);
               obus = 8'h5B; addr = 16'h6123; #1;
               chk("R11 hit low", hit, latch_on());
               if (hit) chk("R11 rdata clear", rdata, {obus[7:1], 1'(m_latch)});
               wr(16'h6001, 8'h01);
               addr = 16'h8000; #1;
               chk("R11 out of range", hit, 0);
               addr = 16'h7000; #1;
               if (hit) chk("R11 rdata set", rdata[0], 1);
            end
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule